// File: doc/BRIEF.md
# Coprocessor control register transfer unit

This block sits between a host processor and a vector coprocessor. It carries the host's register-move instructions into and out of the coprocessor's bank of 32 control and integer registers. Each write passes a per-index filter. Some indices refuse host writes. One index keeps only a mask of bits. Another pins its exponent bits to a constant. Two indices also fire side effects: one-cycle reset and force-break strobes for the two vector units, and a start strobe with a start address for unit 1. A read comes back widened to 64 bits.

The host presents one request at a time. A request carries a direction, a register index, 64 bits of write data and an interlock bit. When the interlock bit is set, the block holds the host with `stall` while unit 0 is busy. For a read, unit 0 is busy while it runs. For a write, unit 0 is busy while it runs and has not yet reported its M-bit. A write to the unit-1 start address also waits while unit 1 runs, whether or not the interlock bit is set. `stall` is combinational. The request completes in the first cycle its wait condition is false.

Top module: `cop_ctl_xfer`

## Requirements
- R1: After reset, every register reads back 0, all strobes and `shadow_clip` are 0, `u1_start_addr` is 0, and `stall` is low. `stall` is never high without `req_valid`.
- R2: A write to index 0 has no effect, and index 0 always reads as 0.
- R3: Writes to index 17 (MAC flags), 26 (program counter) and 29 (unit status) are discarded. These registers read back 0.
- R4: A write to index 20 stores (data & 0x007FFFFF) | 0x3F800000, so that register's bits 31..23 always hold 0x07F. A read of it returns the written low 23 bits.
- R5: A read of index 20 returns only bits 22..0 of the register, with bits 63..23 of `rd_data` zero.
- R6: A read of any other index returns the 32-bit register in `rd_data[31:0]`, with bit 31 copied into all of `rd_data[63:32]`.
- R7: A write to index 28 stores only data bits 2, 3, 10 and 11 (data & 0x0C0C).
- R8: In the cycle after a write to index 28 is accepted, each strobe is high for exactly one cycle if its data bit was set: `u0_break_pulse` for bit 0, `u0_reset_pulse` for bit 1, `u1_break_pulse` for bit 8 and `u1_reset_pulse` for bit 9.
- R9: A write to index 31 stalls while `u1_running` is high. In the cycle after it is accepted, `u1_start_pulse` is high for one cycle and `u1_start_addr` holds data bits 15..0. The value is also stored in register 31.
- R10: A write to index 18 stores the value in the register and, from the next cycle, drives it on `shadow_clip`.
- R11: A read with `req_ilock` set stalls while `u0_running` is high, regardless of `u0_mbit`. It completes, with `rd_valid` high, in the first cycle `u0_running` is low.
- R12: A write with `req_ilock` set stalls while `u0_running` is high and `u0_mbit` is low. A write held by the stall changes no register until it is accepted.
- R13: With `req_ilock` clear, a request to any index other than a blocked index-31 write is accepted in the same cycle, whatever the state of `u0_running`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; held until not stalled |
| req_write | input | 1 | 1 = move to coprocessor, 0 = move from |
| req_index | input | 5 | Control register index |
| req_wdata | input | 64 | Write data; the low 32 bits are used |
| req_ilock | input | 1 | Interlock bit of the instruction |
| u0_running | input | 1 | Unit 0 is executing microcode |
| u0_mbit | input | 1 | Unit 0 has reached its M-bit |
| u1_running | input | 1 | Unit 1 is executing microcode |
| stall | output | 1 | Hold the host request |
| rd_valid | output | 1 | Read accepted this cycle; `rd_data` valid |
| rd_data | output | 64 | Widened read data |
| u0_reset_pulse | output | 1 | One-cycle reset strobe for unit 0 |
| u0_break_pulse | output | 1 | One-cycle force-break strobe for unit 0 |
| u1_reset_pulse | output | 1 | One-cycle reset strobe for unit 1 |
| u1_break_pulse | output | 1 | One-cycle force-break strobe for unit 1 |
| u1_start_pulse | output | 1 | One-cycle start strobe for unit 1 |
| u1_start_addr | output | 16 | Start address of the last unit-1 start |
| shadow_clip | output | 32 | Shadow copy of the clip flag register |

## Verification
Two events can fall in the same cycle: stall release and the completion of the request. This is provoked by holding an interlocked read or write while unit 0 runs and then dropping `u0_running`, or raising `u0_mbit` for a write. The bench expects `stall` low and `rd_valid` high, with correct data, in that same cycle. For a write, it expects the register to have changed by the next cycle. A write to index 28 sets all four strobe bits at once, so all four strobes must rise together for one cycle while the register keeps only the masked bits. The blocked unit-1 start write checks that no start strobe appears during the wait and that exactly one appears after release.

// File: rtl/cop_ctl_pkg.sv
package cop_ctl_pkg;

    // register indices whose behaviour differs from plain storage
    localparam int REG_MACF     = 17;
    localparam int REG_CLIP     = 18;
    localparam int REG_R        = 20;
    localparam int REG_PC       = 26;
    localparam int REG_RSTBRK   = 28;
    localparam int REG_USTAT    = 29;
    localparam int REG_U1_START = 31;

    // R register: low bits kept, upper bits forced
    localparam int          R_KEEP_W    = 23;
    localparam logic [31:0] R_KEEP_MASK = (32'h1 << R_KEEP_W) - 32'h1;
    localparam logic [31:0] R_FORCE     = 32'h3F80_0000;

    // reset/break control register
    localparam logic [31:0] RSTBRK_MASK = 32'h0000_0C0C;
    localparam int U0_BRK_BIT = 0;
    localparam int U0_RST_BIT = 1;
    localparam int U1_BRK_BIT = 8;
    localparam int U1_RST_BIT = 9;

    typedef struct packed {
        logic u0_rst;
        logic u0_brk;
        logic u1_rst;
        logic u1_brk;
        logic u1_start;
    } fx_t;

endpackage

// File: rtl/cop_wr_filter.sv
module cop_wr_filter
    import cop_ctl_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic             wr_en,
    output logic [DW-1:0]    wr_val,
    output fx_t              fx,
    output logic             clip_upd
);

    always_comb begin
        wr_en    = 1'b1;
        wr_val   = wdata;
        fx       = '0;
        clip_upd = 1'b0;
        case (int'(idx))
            0, REG_MACF, REG_PC, REG_USTAT: begin
                wr_en = 1'b0;
            end
            REG_R: begin
                wr_val = (wdata & DW'(R_KEEP_MASK)) | DW'(R_FORCE);
            end
            REG_RSTBRK: begin
                wr_val    = wdata & DW'(RSTBRK_MASK);
                fx.u0_brk = wdata[U0_BRK_BIT];
                fx.u0_rst = wdata[U0_RST_BIT];
                fx.u1_brk = wdata[U1_BRK_BIT];
                fx.u1_rst = wdata[U1_RST_BIT];
            end
            REG_U1_START: begin
                fx.u1_start = 1'b1;
            end
            REG_CLIP: begin
                clip_upd = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cop_ilock.sv
module cop_ilock
    import cop_ctl_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_ilock,
    input  logic [IDX_W-1:0] idx,
    input  logic             u0_running,
    input  logic             u0_mbit,
    input  logic             u1_running,
    output logic             stall,
    output logic             accept
);

    logic wait_u0;
    logic wait_u1;

    always_comb begin
        if (req_write) begin
            wait_u0 = req_ilock & u0_running & ~u0_mbit;
        end else begin
            wait_u0 = req_ilock & u0_running;
        end
        wait_u1 = req_write & (idx == IDX_W'(REG_U1_START)) & u1_running;
        stall   = req_valid & (wait_u0 | wait_u1);
        accept  = req_valid & ~stall;
    end

endmodule

// File: rtl/cop_rd_format.sv
module cop_rd_format
    import cop_ctl_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    value,
    output logic [2*DW-1:0]  data
);

    always_comb begin
        if (idx == IDX_W'(REG_R)) begin
            data = {{(2*DW-R_KEEP_W){1'b0}}, value[R_KEEP_W-1:0]};
        end else begin
            data = {{DW{value[DW-1]}}, value};
        end
    end

endmodule

// File: rtl/cop_ctl_xfer.sv
module cop_ctl_xfer
    import cop_ctl_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 5,
    parameter int SA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_index,
    input  logic [2*DW-1:0]  req_wdata,
    input  logic             req_ilock,
    input  logic             u0_running,
    input  logic             u0_mbit,
    input  logic             u1_running,
    output logic             stall,
    output logic             rd_valid,
    output logic [2*DW-1:0]  rd_data,
    output logic             u0_reset_pulse,
    output logic             u0_break_pulse,
    output logic             u1_reset_pulse,
    output logic             u1_break_pulse,
    output logic             u1_start_pulse,
    output logic [SA_W-1:0]  u1_start_addr,
    output logic [DW-1:0]    shadow_clip
);

    localparam int NREG = 1 << IDX_W;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [DW-1:0]           shadow;
        logic [SA_W-1:0]         saddr;
        fx_t                     fx;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic                    accept;
    logic                    wr_fire;
    logic                    wr_en;
    logic [DW-1:0]           wr_val;
    fx_t                     fx;
    logic                    clip_upd;
    logic [NREG-1:0][DW-1:0] reg_d;
    logic [DW-1:0]           r_value_q;
    logic                    unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[2*DW-1:DW];

    cop_ilock #(.IDX_W(IDX_W)) u_ilock (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ilock  (req_ilock),
        .idx        (req_index),
        .u0_running (u0_running),
        .u0_mbit    (u0_mbit),
        .u1_running (u1_running),
        .stall      (stall),
        .accept     (accept)
    );

    cop_wr_filter #(.DW(DW), .IDX_W(IDX_W)) u_filter (
        .idx      (req_index),
        .wdata    (req_wdata[DW-1:0]),
        .wr_en    (wr_en),
        .wr_val   (wr_val),
        .fx       (fx),
        .clip_upd (clip_upd)
    );

    cop_rd_format #(.DW(DW), .IDX_W(IDX_W)) u_rdfmt (
        .idx   (req_index),
        .value (st_q.regs[req_index]),
        .data  (rd_data)
    );

    assign wr_fire = accept & req_write;

    // per-entry next value of the register file
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign reg_d[g] = (wr_fire & wr_en & (req_index == IDX_W'(g)))
                        ? wr_val : st_q.regs[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.regs = reg_d;
        st_d.fx   = '0;
        if (wr_fire) begin
            st_d.fx = fx;
            if (clip_upd) begin
                st_d.shadow = wr_val;
            end
            if (fx.u1_start) begin
                st_d.saddr = req_wdata[SA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.regs[REG_R]  <= DW'(R_FORCE);
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid       = accept & ~req_write;
    assign u0_reset_pulse = st_q.fx.u0_rst;
    assign u0_break_pulse = st_q.fx.u0_brk;
    assign u1_reset_pulse = st_q.fx.u1_rst;
    assign u1_break_pulse = st_q.fx.u1_brk;
    assign u1_start_pulse = st_q.fx.u1_start;
    assign u1_start_addr  = st_q.saddr;
    assign shadow_clip    = st_q.shadow;
    assign r_value_q      = st_q.regs[REG_R];

endmodule

// File: rtl/cop_ctl_xfer_chk.sv
module cop_ctl_xfer_chk
    import cop_ctl_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 5,
    parameter int SA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [IDX_W-1:0] req_index,
    input logic [2*DW-1:0]  req_wdata,
    input logic             req_ilock,
    input logic             u0_running,
    input logic             u0_mbit,
    input logic             u1_running,
    input logic             stall,
    input logic             rd_valid,
    input logic [2*DW-1:0]  rd_data,
    input logic             u0_reset_pulse,
    input logic             u1_break_pulse,
    input logic             u1_start_pulse,
    input logic [SA_W-1:0]  u1_start_addr,
    input logic [DW-1:0]    shadow_clip,
    input logic [DW-1:0]    r_value_q
);

    logic wr_acc;
    logic u1_blocked;
    assign wr_acc     = req_valid & req_write & ~stall;
    assign u1_blocked = req_write & (req_index == IDX_W'(REG_U1_START)) & u1_running;

    // R1
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> req_valid);

    // R4
    r_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_value_q[DW-1:R_KEEP_W] == 9'h07F);

    // R5
    r_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && req_index == IDX_W'(REG_R)) |-> (rd_data[2*DW-1:R_KEEP_W] == '0));

    // R6
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && req_index != IDX_W'(REG_R)) |-> (rd_data[2*DW-1:DW] == {DW{rd_data[DW-1]}}));

    // R8
    u0_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        u0_reset_pulse |-> $past(wr_acc && req_index == IDX_W'(REG_RSTBRK) && req_wdata[U0_RST_BIT]));

    // R8
    u1_brk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        u1_break_pulse |-> $past(wr_acc && req_index == IDX_W'(REG_RSTBRK) && req_wdata[U1_BRK_BIT]));

    // R9
    start_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && u1_blocked) |-> stall);

    // R9
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        u1_start_pulse |-> (u1_start_addr == $past(req_wdata[SA_W-1:0]) && !$past(u1_running)));

    // R10
    clip_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && req_index == IDX_W'(REG_CLIP)) |=> (shadow_clip == $past(req_wdata[DW-1:0])));

    // R11
    rd_ilock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ilock && u0_running) |-> stall);

    // R12
    wr_ilock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_ilock && u0_mbit && !u1_blocked) |-> !stall);

    // R13
    no_ilock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ilock && !u1_blocked) |-> !stall);

endmodule

bind cop_ctl_xfer cop_ctl_xfer_chk #(.DW(DW), .IDX_W(IDX_W), .SA_W(SA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_index      (req_index),
    .req_wdata      (req_wdata),
    .req_ilock      (req_ilock),
    .u0_running     (u0_running),
    .u0_mbit        (u0_mbit),
    .u1_running     (u1_running),
    .stall          (stall),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .u0_reset_pulse (u0_reset_pulse),
    .u1_break_pulse (u1_break_pulse),
    .u1_start_pulse (u1_start_pulse),
    .u1_start_addr  (u1_start_addr),
    .shadow_clip    (shadow_clip),
    .r_value_q      (r_value_q)
);

// File: tb/cop_ctl_xfer_bench.sv
module cop_ctl_xfer_bench;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [4:0]  req_index;
    logic [63:0] req_wdata;
    logic        req_ilock;
    logic        u0_running;
    logic        u0_mbit;
    logic        u1_running;
    logic        stall;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        u0_reset_pulse;
    logic        u0_break_pulse;
    logic        u1_reset_pulse;
    logic        u1_break_pulse;
    logic        u1_start_pulse;
    logic [15:0] u1_start_addr;
    logic [31:0] shadow_clip;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    cop_ctl_xfer u_cop_ctl_xfer (.*);

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request, no expected stall; rd and st captured in the request cycle
    task automatic xfer(input logic w, input logic [4:0] idx, input logic [31:0] d,
                        input logic il, output logic [63:0] rd, output logic st);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_index = idx;
        req_wdata = {32'hA5A5_5A5A, d};
        req_ilock = il;
        #2;
        rd = rd_data;
        st = stall;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // {req number, index, write data, expected read}
    localparam int NVEC = 15;
    localparam logic [108:0] VEC [NVEC] = '{
        {8'd2,  5'd0,  32'hDEAD_BEEF, 64'h0000_0000_0000_0000}, // R2
        {8'd6,  5'd5,  32'h8000_0001, 64'hFFFF_FFFF_8000_0001}, // R6
        {8'd6,  5'd5,  32'h7FFF_FFFF, 64'h0000_0000_7FFF_FFFF}, // R6
        {8'd3,  5'd17, 32'h1234_5678, 64'h0000_0000_0000_0000}, // R3
        {8'd3,  5'd26, 32'hFFFF_FFFF, 64'h0000_0000_0000_0000}, // R3
        {8'd3,  5'd29, 32'h0000_0101, 64'h0000_0000_0000_0000}, // R3
        {8'd4,  5'd20, 32'hFFFF_FFFF, 64'h0000_0000_007F_FFFF}, // R4
        {8'd5,  5'd20, 32'h8000_0000, 64'h0000_0000_0000_0000}, // R5
        {8'd5,  5'd20, 32'h0012_3456, 64'h0000_0000_0012_3456}, // R5
        {8'd7,  5'd28, 32'h0000_000C, 64'h0000_0000_0000_000C}, // R7
        {8'd7,  5'd28, 32'hFFFF_F0F0, 64'h0000_0000_0000_0000}, // R7
        {8'd6,  5'd21, 32'hC000_0000, 64'hFFFF_FFFF_C000_0000}, // R6
        {8'd10, 5'd18, 32'h0000_0ABC, 64'h0000_0000_0000_0ABC}, // R10
        {8'd9,  5'd31, 32'h0001_2345, 64'h0000_0000_0001_2345}, // R9
        {8'd6,  5'd15, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000}  // R6
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R13 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic        st;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
        req_wdata = '0; req_ilock = 1'b0;
        u0_running = 1'b0; u0_mbit = 1'b0; u1_running = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;

        // reset state, R1
        chk("R1 stall", {63'd0, stall}, 64'd0);
        chk("R1 strobes", {59'd0, u0_reset_pulse, u0_break_pulse, u1_reset_pulse,
                           u1_break_pulse, u1_start_pulse}, 64'd0);
        chk("R1 shadow", {32'd0, shadow_clip}, 64'd0);
        chk("R1 start addr", {48'd0, u1_start_addr}, 64'd0);
        xfer(1'b0, 5'd7, 32'd0, 1'b0, rd, st);
        chk("R1 reg7", rd, 64'd0);
        xfer(1'b0, 5'd20, 32'd0, 1'b0, rd, st);
        chk("R1 reg20", rd, 64'd0);

        // table walk: write then read back
        for (int i = 0; i < NVEC; i++) begin
            xfer(1'b1, VEC[i][100:96], VEC[i][95:64], 1'b0, rd, st);
            xfer(1'b0, VEC[i][100:96], 32'd0, 1'b0, rd, st);
            chk($sformatf("R%0d vector %0d", VEC[i][108:101], i), rd, VEC[i][63:0]);
        end

        // R10: shadow follows the clip register
        xfer(1'b1, 5'd18, 32'h5A5A_F00F, 1'b0, rd, st);
        chk("R10 shadow", {32'd0, shadow_clip}, 64'h5A5A_F00F);

        // R8: all four strobes together, one cycle
        xfer(1'b1, 5'd28, 32'h0000_030F, 1'b0, rd, st);
        chk("R8 all strobes", {60'd0, u0_reset_pulse, u0_break_pulse, u1_reset_pulse,
                               u1_break_pulse}, 64'hF);
        @(posedge clk); #1;
        chk("R8 strobes drop", {60'd0, u0_reset_pulse, u0_break_pulse, u1_reset_pulse,
                                u1_break_pulse}, 64'h0);
        xfer(1'b0, 5'd28, 32'd0, 1'b0, rd, st);
        chk("R7 masked store", rd, 64'h0000_0000_0000_000C);
        xfer(1'b1, 5'd28, 32'h0000_0002, 1'b0, rd, st);
        chk("R8 unit0 reset only", {60'd0, u0_reset_pulse, u0_break_pulse, u1_reset_pulse,
                                    u1_break_pulse}, 64'h8);
        xfer(1'b1, 5'd28, 32'h0000_0100, 1'b0, rd, st);
        chk("R8 unit1 break only", {60'd0, u0_reset_pulse, u0_break_pulse, u1_reset_pulse,
                                    u1_break_pulse}, 64'h1);

        // R9: start write waits for unit 1
        @(negedge clk);
        u1_running = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_index = 5'd31;
        req_wdata = {32'h0, 32'h0000_BEEF}; req_ilock = 1'b0;
        #2;
        chk("R9 stall while unit1 runs", {63'd0, stall}, 64'd1);
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        chk("R9 still stalled", {63'd0, stall}, 64'd1);
        chk("R9 no early start", {63'd0, u1_start_pulse}, 64'd0);
        u1_running = 1'b0;
        #1;
        chk("R9 release", {63'd0, stall}, 64'd0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R9 start strobe", {63'd0, u1_start_pulse}, 64'd1);
        chk("R9 start addr", {48'd0, u1_start_addr}, 64'h0000_0000_0000_BEEF);
        @(posedge clk); #1;
        chk("R9 strobe one cycle", {63'd0, u1_start_pulse}, 64'd0);

        // R11: read interlock ignores the M-bit
        @(negedge clk);
        u0_running = 1'b1; u0_mbit = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_index = 5'd5; req_ilock = 1'b1;
        #2;
        chk("R11 read stalls", {62'd0, stall, rd_valid}, 64'h2);
        @(negedge clk);
        u0_running = 1'b0;
        #2;
        chk("R11 release same cycle", {62'd0, stall, rd_valid}, 64'h1);
        chk("R11 read data", rd_data, 64'h0000_0000_7FFF_FFFF);
        @(posedge clk); #1;
        req_valid = 1'b0; u0_mbit = 1'b0;

        // R12: write interlock released by the M-bit
        @(negedge clk);
        u0_running = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_index = 5'd9;
        req_wdata = {32'h0, 32'h1111_2222}; req_ilock = 1'b1;
        #2;
        chk("R12 write stalls", {63'd0, stall}, 64'd1);
        @(negedge clk);
        u0_mbit = 1'b1;
        #2;
        chk("R12 mbit releases", {63'd0, stall}, 64'd0);
        @(posedge clk); #1;
        req_valid = 1'b0; u0_mbit = 1'b0;
        xfer(1'b0, 5'd9, 32'd0, 1'b0, rd, st);
        chk("R12 write landed", rd, 64'h0000_0000_1111_2222);

        // R12: withdrawn stalled write leaves the register alone
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_index = 5'd10;
        req_wdata = {32'h0, 32'h7777_7777}; req_ilock = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        req_valid = 1'b0;
        xfer(1'b0, 5'd10, 32'd0, 1'b0, rd, st);
        chk("R12 held write no effect", rd, 64'd0);

        // R13: no interlock bit, unit 0 still running
        xfer(1'b1, 5'd11, 32'hCAFE_0001, 1'b0, rd, st);
        chk("R13 write no stall", {63'd0, st}, 64'd0);
        xfer(1'b0, 5'd11, 32'd0, 1'b0, rd, st);
        chk("R13 read no stall", {63'd0, st}, 64'd0);
        chk("R13 read data", rd, 64'hFFFF_FFFF_CAFE_0001);
        u0_running = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule